// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the bus-facing controller of a small serial EEPROM. An external master drives the serial clock, and the shared data line is open drain. The block sees the data line as an input and can only pull it low through a single enable output. A fast system clock oversamples both lines. The block recognises framing conditions and decodes the device address byte. It acknowledges when it is selected, stores single bytes into an internal array, and returns bytes from a current-address pointer.

One parameter selects the density. It sets how many of the three selection bits in the address byte are compared against hard-wired chip-select pins, and how many instead pick a 256-byte page of the array. After a completed byte write, the block spends a fixed number of system clocks in a self-timed programming interval. During that interval it stays silent on the bus.

Top module: `twi_eeprom_slave`

## Requirements
- R1: Bus activity is ignored until a START is seen. A START is SDA falling while SCL is high. Before any START the block never pulls SDA low, and a START always begins reception of a fresh address byte.
- R2: A STOP is SDA rising while SCL is high. A STOP or START in the middle of a byte abandons the transfer, and no memory write results. After a STOP the block is idle, or programming if R8 applies.
- R3: Incoming bits are sampled on the SCL rising edge, MSB first. The block changes its SDA pull only while SCL is low.
- R4: The block responds only when bits 7:4 of the address byte are 1010. Any other value gets no acknowledge, and the block waits for the next START.
- R5: The parameter PAGE_BITS (0 to 3) splits address bits 3:1. Bits 3:(1+PAGE_BITS) must equal chipSel[2:PAGE_BITS]. The lower PAGE_BITS bits are page bits, and chipSel pins below PAGE_BITS have no effect.
- R6: The array holds 256 << PAGE_BITS bytes. The page bits from a write address byte become the upper address bits, above the 8-bit word address byte that follows.
- R7: When the address matches, the block pulls SDA low for the ninth SCL clock. It does the same after the word address byte and after the data byte of a write.
- R8: A byte write has this sequence: address byte with bit 0 = 0, word address, data, each acknowledged. The byte is stored at the STOP that follows, and the pointer then equals that address plus one.
- R9: The programming interval starts at that STOP and lasts PROG_CYCLES clocks. During it, no request is acknowledged, the block's own address included. When it ends, the block responds again.
- R10: Address bit 0 = 1 starts a current-address read. The byte at the pointer is sent MSB first, and the pointer advances by one per byte, wrapping at the array end. Page bits in a read address byte are ignored. SDA is released for the ninth clock, and a master acknowledge continues the read while a missing one ends it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Serial clock from the bus master |
| sdaIn | input | 1 | Sensed level of the open-drain data line |
| chipSel | input | 3 | Hard-wired select pins, bit 2 is the top selection bit |
| sdaPullLow | output | 1 | When high, the block pulls the data line low |

## Verification
Several behaviours are checked by assertions on every cycle. The pull-low enable only rises while the synchronised SCL is low. It is never asserted during programming. Programming only ever begins on a STOP. A START or STOP always returns the controller to address reception or idle, and a mismatched address drops it to idle. Other behaviours can only be shown by the bench's scenarios. These are that stored bytes land at the page-qualified address and come back intact, the pointer advance and wrap, that abandoned writes leave memory untouched, and that acknowledges return once the programming interval has elapsed.

// File: rtl/twi_eep_pkg.sv
package twi_eep_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic clrCnt;
    logic shiftIn;
    logic latchDev;
    logic setWord;
    logic latchData;
    logic writeMem;
    logic loadTx;
    logic shiftTx;
    logic driveAck;
    logic driveTx;
  } ctrlStrobe_t;

  // Bus events and decoded flags from datapath to control
  typedef struct packed {
    logic startEv;
    logic stopEv;
    logic riseEv;
    logic fallEv;
    logic sdaLvl;
    logic cntFull;
    logic cntLast;
    logic addrMatch;
    logic rwBit;
  } busInfo_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEVRX,
    ST_ACKDEV,
    ST_WORDRX,
    ST_ACKWORD,
    ST_DATARX,
    ST_ACKDATA,
    ST_WAITSTOP,
    ST_TX,
    ST_RACK,
    ST_PROG
  } ctrlState_t;

endpackage

// File: rtl/twi_eep_dpath.sv
module twi_eep_dpath
  import twi_eep_pkg::*;
#(
  parameter int PAGE_BITS = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  logic [2:0]  chipSel,
  input  ctrlStrobe_t str,
  output busInfo_t    info,
  output logic        sdaPullLow
);

  localparam int ADDR_W = 8 + PAGE_BITS;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam logic [2:0] PIN_MASK = 3'(3'b111 << PAGE_BITS);
  localparam logic [3:0] DEV_CODE = 4'b1010;

  // two-flop synchronisers plus one history stage for edge detection
  logic [1:0] sclSync, sdaSync;
  logic       sclPrev, sdaPrev;
  logic       sclS, sdaS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclSync[1];
      sdaPrev <= sdaSync[1];
    end
  end

  assign sclS = sclSync[1];
  assign sdaS = sdaSync[1];

  logic [3:0]        bitCnt;
  logic [7:0]        rxSh;
  logic [7:0]        txSh;
  logic [7:0]        dataHold;
  logic [ADDR_W-1:0] ptr;
  logic [ADDR_W-1:0] wordAddr;
  logic [7:0]        memArr [DEPTH];

  generate
    if (PAGE_BITS > 0) begin : g_page
      logic [PAGE_BITS-1:0] pageReg;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)             pageReg <= '0;
        else if (str.latchDev) pageReg <= rxSh[PAGE_BITS:1];
      end
      assign wordAddr = {pageReg, rxSh};
    end else begin : g_nopage
      assign wordAddr = rxSh;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      rxSh     <= '0;
      txSh     <= 8'hFF;
      dataHold <= '0;
      ptr      <= '0;
    end else begin
      if (str.clrCnt)                     bitCnt <= '0;
      else if (str.shiftIn || str.shiftTx) bitCnt <= bitCnt + 4'd1;

      if (str.shiftIn)   rxSh     <= {rxSh[6:0], sdaS};
      if (str.latchData) dataHold <= rxSh;

      if (str.setWord)                      ptr <= wordAddr;
      else if (str.writeMem || str.loadTx) ptr <= ptr + 1'b1;

      if (str.loadTx)       txSh <= memArr[ptr];
      else if (str.shiftTx) txSh <= {txSh[6:0], 1'b1};
    end
  end

  always_ff @(posedge clk) begin
    if (str.writeMem) memArr[ptr] <= dataHold;
  end

  always_comb begin
    info.riseEv    = sclS & ~sclPrev;
    info.fallEv    = ~sclS & sclPrev;
    info.startEv   = sclS & sclPrev & sdaPrev & ~sdaS;
    info.stopEv    = sclS & sclPrev & ~sdaPrev & sdaS;
    info.sdaLvl    = sdaS;
    info.cntFull   = (bitCnt == 4'd8);
    info.cntLast   = (bitCnt == 4'd7);
    info.addrMatch = (rxSh[7:4] == DEV_CODE) &&
                     (((rxSh[3:1] ^ chipSel) & PIN_MASK) == 3'b000);
    info.rwBit     = rxSh[0];
  end

  assign sdaPullLow = str.driveAck | (str.driveTx & ~txSh[7]);

  // R3: the pull may only begin while the sampled clock is low
  a_r3_pull_rises_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullLow) |-> !sclS);

endmodule

// File: rtl/twi_eep_ctrl.sv
module twi_eep_ctrl
  import twi_eep_pkg::*;
#(
  parameter int PROG_CYCLES = 625000
) (
  input  logic        clk,
  input  logic        rstN,
  input  busInfo_t    info,
  output ctrlStrobe_t str,
  output logic        progBusy
);

  localparam int PC_W = $clog2(PROG_CYCLES + 1);
  localparam logic [PC_W-1:0] PC_LAST = PC_W'(PROG_CYCLES - 1);

  ctrlState_t      state, nxt;
  logic            pendWr;
  logic            rwReg;
  logic            mAck;
  logic [PC_W-1:0] progCnt;
  logic            progDone;

  assign progBusy = (state == ST_PROG);
  assign progDone = (progCnt == PC_LAST);

  always_comb begin
    nxt          = state;
    str          = '0;
    str.driveAck = (state == ST_ACKDEV) || (state == ST_ACKWORD) || (state == ST_ACKDATA);
    str.driveTx  = (state == ST_TX);
    if (state == ST_PROG) begin
      if (progDone) nxt = ST_IDLE;
    end else if (info.startEv) begin
      nxt        = ST_DEVRX;
      str.clrCnt = 1'b1;
    end else if (info.stopEv) begin
      if (state == ST_WAITSTOP && pendWr) begin
        str.writeMem = 1'b1;
        nxt          = ST_PROG;
      end else begin
        nxt = ST_IDLE;
      end
    end else begin
      case (state)
        ST_DEVRX, ST_WORDRX, ST_DATARX: begin
          if (info.riseEv && !info.cntFull) begin
            str.shiftIn = 1'b1;
          end else if (info.fallEv && info.cntFull) begin
            if (state == ST_DEVRX) begin
              if (info.addrMatch) begin
                str.latchDev = 1'b1;
                nxt          = ST_ACKDEV;
              end else begin
                nxt = ST_IDLE;
              end
            end else if (state == ST_WORDRX) begin
              str.setWord = 1'b1;
              nxt         = ST_ACKWORD;
            end else begin
              str.latchData = 1'b1;
              nxt           = ST_ACKDATA;
            end
          end
        end
        ST_ACKDEV: begin
          if (info.fallEv) begin
            str.clrCnt = 1'b1;
            if (rwReg) begin
              str.loadTx = 1'b1;
              nxt        = ST_TX;
            end else begin
              nxt = ST_WORDRX;
            end
          end
        end
        ST_ACKWORD: begin
          if (info.fallEv) begin
            str.clrCnt = 1'b1;
            nxt        = ST_DATARX;
          end
        end
        ST_ACKDATA: begin
          if (info.fallEv) nxt = ST_WAITSTOP;
        end
        ST_TX: begin
          if (info.fallEv) begin
            if (info.cntLast) nxt = ST_RACK;
            else              str.shiftTx = 1'b1;
          end
        end
        ST_RACK: begin
          if (info.fallEv) begin
            if (mAck) begin
              str.clrCnt = 1'b1;
              str.loadTx = 1'b1;
              nxt        = ST_TX;
            end else begin
              nxt = ST_WAITSTOP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      pendWr  <= 1'b0;
      rwReg   <= 1'b0;
      mAck    <= 1'b0;
      progCnt <= '0;
    end else begin
      state <= nxt;
      if (str.latchDev) rwReg <= info.rwBit;
      if (state == ST_RACK && info.riseEv) mAck <= ~info.sdaLvl;
      if (str.latchData)                          pendWr <= 1'b1;
      else if (info.startEv || info.stopEv)       pendWr <= 1'b0;
      if (str.writeMem)   progCnt <= '0;
      else if (progBusy)  progCnt <= progCnt + 1'b1;
    end
  end

  // R1: a START outside programming always restarts address reception
  a_r1_start_enters_rx: assert property (@(posedge clk) disable iff (!rstN)
    (info.startEv && !progBusy) |=> (state == ST_DEVRX));

  // R2: a STOP outside programming leaves the block idle or programming
  a_r2_stop_ends: assert property (@(posedge clk) disable iff (!rstN)
    (info.stopEv && !progBusy) |=> (state == ST_IDLE || state == ST_PROG));

  // R4: a completed address byte that does not match drops to idle
  a_r4_nomatch_idle: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DEVRX && info.fallEv && info.cntFull && !info.addrMatch &&
     !info.startEv && !info.stopEv) |=> (state == ST_IDLE));

  // R9: programming is only ever entered on a STOP
  a_r9_prog_from_stop: assert property (@(posedge clk) disable iff (!rstN)
    $rose(progBusy) |-> $past(info.stopEv));

endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave
  import twi_eep_pkg::*;
#(
  parameter int PAGE_BITS   = 2,
  parameter int PROG_CYCLES = 625000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] chipSel,
  output logic       sdaPullLow
);

  ctrlStrobe_t strW;
  busInfo_t    infoW;
  logic        busyW;

  twi_eep_ctrl #(.PROG_CYCLES(PROG_CYCLES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .info     (infoW),
    .str      (strW),
    .progBusy (busyW)
  );

  twi_eep_dpath #(.PAGE_BITS(PAGE_BITS)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclIn),
    .sdaIn      (sdaIn),
    .chipSel    (chipSel),
    .str        (strW),
    .info       (infoW),
    .sdaPullLow (sdaPullLow)
  );

  // R9: silent on the bus for the whole programming interval
  a_r9_silent_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    busyW |-> !sdaPullLow);

endmodule

// File: tb/test_twi_eeprom_slave.sv
module test_twi_eeprom_slave;

  localparam int PB   = 2;
  localparam int PROG = 2000;
  localparam int HALF = 20;
  localparam int AW   = 8 + PB;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic [2:0] pins = 3'b110;
  logic pull;
  wire  sdaLine = sdaM & ~pull;

  int checks = 0;
  int failures = 0;
  int r3Viol = 0;

  logic [7:0] model [1 << AW];
  bit         known [1 << AW];

  always #4 clk = ~clk;

  twi_eeprom_slave #(.PAGE_BITS(PB), .PROG_CYCLES(PROG)) i_twi_eeprom_slave (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
    .chipSel(pins), .sdaPullLow(pull)
  );

  // R3 monitor: pull must not change while SCL is held high
  logic prevPull = 1'b0;
  logic prevScl  = 1'b1;
  always @(negedge clk) begin
    if (rstN && sclM && prevScl && (pull != prevPull)) r3Viol++;
    prevPull <= pull;
    prevScl  <= sclM;
  end

  function automatic logic [7:0] devByte(input logic a2, input logic [1:0] pg, input logic rw);
    return {4'b1010, a2, pg, rw};
  endfunction

  function automatic logic [AW-1:0] nextAddr(input logic [AW-1:0] a);
    return a + 1'b1;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitCyc(HALF);
    sclM = 1'b1; waitCyc(HALF);
    sdaM = 1'b0; waitCyc(HALF);
    sclM = 1'b0; waitCyc(HALF);
  endtask

  task automatic busStop();
    sclM = 1'b0; waitCyc(4);
    sdaM = 1'b0; waitCyc(HALF);
    sclM = 1'b1; waitCyc(HALF);
    sdaM = 1'b1; waitCyc(HALF);
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdaM = b[i]; waitCyc(HALF);
      sclM = 1'b1; waitCyc(HALF);
      sclM = 1'b0; waitCyc(4);
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    sendBits(b, 8);
    sdaM = 1'b1; waitCyc(HALF);
    sclM = 1'b1; waitCyc(HALF / 2);
    acked = !sdaLine;
    waitCyc(HALF / 2);
    sclM = 1'b0; waitCyc(HALF);
  endtask

  task automatic readByte(input bit giveAck, output logic [7:0] d);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitCyc(HALF);
      sclM = 1'b1; waitCyc(HALF / 2);
      d[i] = sdaLine;
      waitCyc(HALF / 2);
      sclM = 1'b0; waitCyc(4);
    end
    sdaM = giveAck ? 1'b0 : 1'b1; waitCyc(HALF);
    sclM = 1'b1; waitCyc(HALF);
    sclM = 1'b0; waitCyc(4);
    sdaM = 1'b1;
  endtask

  task automatic doWrite(input logic [AW-1:0] a, input logic [7:0] d, input string req);
    bit ak;
    busStart();
    sendByte(devByte(1'b1, a[9:8], 1'b0), ak); chk(ak, {req, " dev ack R7"}, 16'(ak), 16'd1);
    sendByte(a[7:0], ak);                      chk(ak, {req, " word ack R7"}, 16'(ak), 16'd1);
    sendByte(d, ak);                           chk(ak, {req, " data ack R7"}, 16'(ak), 16'd1);
    busStop();
    model[a] = d;
    known[a] = 1'b1;
  endtask

  task automatic probeNack(input string req);
    bit ak;
    busStart();
    sendByte(devByte(1'b1, 2'b01, 1'b0), ak);
    chk(!ak, req, 16'(ak), 16'd0);
    busStop();
  endtask

  task automatic setPtr(input logic [AW-1:0] a);
    bit ak;
    busStart();
    sendByte(devByte(1'b1, a[9:8], 1'b0), ak);
    sendByte(a[7:0], ak);
  endtask

  logic [7:0] rd;
  bit ak;

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < (1 << AW); i++) known[i] = 1'b0;
    waitCyc(5);
    chk(pull == 1'b0, "R1 reset pull released", 16'(pull), 16'd0);
    rstN = 1'b1;
    waitCyc(10);

    // R1: a full matching byte without START gets no acknowledge
    sclM = 1'b0; waitCyc(HALF);
    sendByte(devByte(1'b1, 2'b00, 1'b0), ak);
    chk(!ak, "R1 no START no ack", 16'(ak), 16'd0);
    busStop();

    // R4: wrong device code
    busStart();
    sendByte(8'hB8, ak);
    chk(!ak, "R4 wrong code nack", 16'(ak), 16'd0);
    busStop();

    // R5: wrong compared pin bit (A2) -> nack
    busStart();
    sendByte(devByte(1'b0, 2'b00, 1'b0), ak);
    chk(!ak, "R5 wrong pin nack", 16'(ak), 16'd0);
    busStop();

    // R8/R9: directed write to address 0, busy probe, then wait
    doWrite(10'h000, 8'h5A, "R8 write0");
    probeNack("R9 busy after write nack");
    waitCyc(PROG + 200);

    // R5: low pin inputs are page bits under PB=2 and must not matter
    pins = 3'b101;
    // R10 wrap: write last address, pointer wraps to 0
    doWrite(10'h3FF, 8'hC3, "R6 write last");
    waitCyc(PROG + 200);
    busStart();
    sendByte(devByte(1'b1, 2'b10, 1'b1), ak);
    chk(ak, "R5 ack with changed low pins", 16'(ak), 16'd1);
    readByte(1'b0, rd);
    chk(rd == model[0], "R10 pointer wrap R8 plus one", 16'(rd), 16'(model[0]));
    busStop();
    pins = 3'b110;

    // constrained random writes and read-backs
    for (int it = 0; it < 12; it++) begin
      logic [AW-1:0] a;
      logic [7:0] d, exp2;
      a = AW'($urandom_range(0, (1 << AW) - 1));
      d = 8'($urandom);
      doWrite(a, d, "R8 rnd");
      probeNack("R9 rnd busy nack");
      waitCyc(PROG + 200);
      setPtr(a);
      busStart();                              // abandons the pointer-setting write (R2)
      sendByte(devByte(1'b1, 2'($urandom), 1'b1), ak);
      chk(ak, "R9 ack after programming", 16'(ak), 16'd1);
      readByte(1'b1, rd);
      chk(rd == d, "R6 R8 read back", 16'(rd), 16'(d));
      readByte(1'b0, rd);
      exp2 = model[nextAddr(a)];
      if (known[nextAddr(a)]) chk(rd == exp2, "R10 sequential pointer", 16'(rd), 16'(exp2));
      busStop();
    end

    // R2: STOP in the middle of a data byte writes nothing and starts no programming
    setPtr(10'h000);
    sendBits(8'h11, 3);
    busStop();
    busStart();
    sendByte(devByte(1'b1, 2'b00, 1'b1), ak);
    chk(ak, "R2 mid-byte STOP no programming", 16'(ak), 16'd1);
    readByte(1'b0, rd);
    chk(rd == model[0], "R2 mid-byte STOP memory kept", 16'(rd), 16'(model[0]));
    busStop();

    // R2: START in the middle of a data byte
    setPtr(10'h3FF);
    sendBits(8'h77, 5);
    busStart();
    sendByte(devByte(1'b1, 2'b00, 1'b1), ak);
    chk(ak, "R2 restart ack", 16'(ak), 16'd1);
    readByte(1'b0, rd);
    chk(rd == model[10'h3FF], "R2 mid-byte START memory kept", 16'(rd), 16'(model[10'h3FF]));
    busStop();

    // R9: a full write attempted during programming is ignored
    doWrite(10'h155, 8'hA7, "R9 base write");
    busStart();
    sendByte(devByte(1'b1, 2'b01, 1'b0), ak);
    chk(!ak, "R9 write during busy nack", 16'(ak), 16'd0);
    sendByte(8'h55, ak);
    sendByte(8'h00, ak);
    busStop();
    waitCyc(PROG + 200);
    setPtr(10'h155);
    busStart();
    sendByte(devByte(1'b1, 2'b00, 1'b1), ak);
    readByte(1'b0, rd);
    chk(rd == 8'hA7, "R9 busy write ignored", 16'(rd), 16'hA7);
    busStop();

    chk(r3Viol == 0, "R3 pull changed while SCL high", 16'(r3Viol), 16'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule